// File: doc/BRIEF.md
# Block-Memory Parallel-Array Code Correlator

This block finds how strongly a stored binary spreading code matches a stored stretch of received samples. The code is a run of SEQ_LEN chips, each +1 or -1. The samples are signed two's-complement words of SMP_W bits. For a base position `m`, the correlation value is the sum over chip positions `p` of chip(p) times sample(m + p).

Samples and code chips sit in internal memories that are addressed, not shifted. In every compute cycle the block reads a window of LANES + OFFSETS - 1 samples and one row of LANES chips. It evaluates LANES chip positions for OFFSETS neighbouring base positions at once. Each multiply is a conditional bit inversion. A per-offset adder tree sums the row, and an accumulator adds the row sums over ROWS = ceil(SEQ_LEN / LANES) cycles. When a group of OFFSETS points is complete, the values are loaded into a result chain and shifted out one per cycle while the next group is already computing. A start pulse picks the code, the first base position and the number of groups. Because nothing is preloaded into the array, a new job with a different code can follow the previous one with no idle cycle. The parameters must satisfy ROWS >= OFFSETS and ROWS >= 2.

Top module: `ppt_correlator`

## Requirements
- R1: For a job with code `c`, base `B` and group index `g`, the j-th result of group g equals the sum over p in [0, SEQ_LEN) of s[(B + g*OFFSETS + j + p) mod DEPTH], negated where chip p of code c is 1 (chip bit 1 means -1, bit 0 means +1). Samples are SMP_W-bit two's complement.
- R2: Results are exact at the extremes. With every sample at the most negative value and every chip -1, each result is SEQ_LEN * 2^(SMP_W-1); with every chip +1 it is the negative of that. `res_o` is SMP_W + clog2(SEQ_LEN) + 1 bits signed.
- R3: When SEQ_LEN is not a multiple of LANES, chip bits and samples that fall at positions SEQ_LEN and above in the last row have no effect on any result.
- R4: Sample addresses wrap modulo DEPTH, so a base near the end of the sample memory reads from its start.
- R5: A start sampled at clock edge S gives group g's results at offset order j = 0..OFFSETS-1, with `res_valid_o` high in the cycles following edges S + ROWS*(g+1) + j, one result per cycle.
- R6: `groups_i` = G runs G+1 groups. Each group begins OFFSETS positions after the previous one and follows it with no idle cycle.
- R7: `done_o` is a one-cycle pulse in the cycle right after the last result of each group.
- R8: A start while busy is ignored, except in the last compute cycle of the final group. An ignored start changes no result, no result timing and no count of results.
- R9: A start in the last compute cycle of the final group is accepted. The new job, with its own code and base, computes in the next cycle, so its results trail the old ones by exactly ROWS cycles.
- R10: After reset `busy_o`, `res_valid_o` and `done_o` are low.
- R11: Code rows are written as LANES chip bits per row (`code_row_i`, bit i = chip row*LANES + i) for a selected code, and samples one per address. Rewriting a code between jobs changes the results of later jobs that select it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_we_i | input | 1 | Sample memory write enable |
| smp_addr_i | input | AW | Sample write address |
| smp_data_i | input | SMP_W | Sample value, two's complement |
| code_we_i | input | 1 | Code memory write enable |
| code_wsel_i | input | CW | Code written |
| code_row_i | input | RW | Row of the code written |
| code_bits_i | input | LANES | Chip bits for the row, 1 = -1 |
| start_i | input | 1 | Job start pulse |
| code_sel_i | input | CW | Code used by the job |
| base_i | input | AW | First base sample position |
| groups_i | input | GRP_W | Number of groups minus one |
| busy_o | output | 1 | Job computing |
| res_o | output | ACC_W | Correlation result, signed |
| res_valid_o | output | 1 | `res_o` holds a result |
| done_o | output | 1 | Pulse after the last result of a group |

## Verification
The bench aims at the masked tail of the last row. It places large samples just past the code window and sets the unused chip bits to -1, so a design that forgot the mask would pull those values into the low offsets. Extreme inputs catch an accumulator that is too narrow, or a negation that drops the +1 correction; either would show up as a wrapped or off-by-count sum. A base near the memory end catches address arithmetic that does not wrap. A start back to back with a code switch, and a start mid-job, catch a controller that inserts a bubble, keeps the stale code, or restarts on a start it should have ignored. Random jobs with several groups check that each group advances the base by OFFSETS and that result timing stays on the ROWS-cycle grid.

// File: rtl/corr_pkg.sv
package corr_pkg;
  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/corr_sample_store.sv
module corr_sample_store #(
  parameter int W     = 4,
  parameter int DEPTH = 64,
  parameter int WIN   = 6,
  parameter int AW    = 6
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [AW-1:0]           rbase_i,
  output logic [WIN-1:0][W-1:0]   win_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // window of consecutive samples, address wraps at DEPTH (power of two)
  for (genvar w = 0; w < WIN; w++) begin : g_win
    logic [AW-1:0] ra;
    assign ra       = rbase_i + AW'(w);
    assign win_o[w] = mem[ra];
  end
endmodule

// File: rtl/corr_code_store.sv
module corr_code_store #(
  parameter int LANES   = 4,
  parameter int N_CODES = 2,
  parameter int ROWS    = 5,
  parameter int CW      = 1,
  parameter int RW      = 3
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [CW-1:0]    wsel_i,
  input  logic [RW-1:0]    wrow_i,
  input  logic [LANES-1:0] wbits_i,
  input  logic [CW-1:0]    rsel_i,
  input  logic [RW-1:0]    rrow_i,
  output logic [LANES-1:0] rbits_o
);
  logic [LANES-1:0] mem [N_CODES][ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wsel_i][wrow_i] <= wbits_i;
  end

  assign rbits_o = mem[rsel_i][rrow_i];
endmodule

// File: rtl/corr_adder_tree.sv
module corr_adder_tree #(
  parameter int N = 5,
  parameter int W = 10
) (
  input  logic [N-1:0][W-1:0] in_i,
  output logic signed [W-1:0] sum_o
);
  localparam int P = 1 << $clog2(N);

  always_comb begin
    logic [W-1:0] t [P];
    for (int i = 0; i < P; i++) t[i] = '0;
    for (int i = 0; i < N; i++) t[i] = in_i[i];
    // pairwise reduction, log2(P) levels
    for (int s = 1; s < P; s = s * 2) begin
      for (int i = 0; i + s < P; i = i + 2 * s) t[i] = t[i] + t[i + s];
    end
    sum_o = t[0];
  end
endmodule

// File: rtl/corr_offset_lane.sv
module corr_offset_lane #(
  parameter int W       = 4,
  parameter int LANES   = 4,
  parameter int ACC_W   = 10,
  parameter int SEQ_LEN = 18,
  parameter int RW      = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      first_i,
  input  logic [RW-1:0]             row_i,
  input  logic [LANES-1:0][W-1:0]   smp_i,
  input  logic [LANES-1:0]          coef_i,
  output logic signed [ACC_W-1:0]   fin_o
);
  localparam int CNT_W = $clog2(LANES + 1);

  logic [LANES:0][ACC_W-1:0] leaf;
  logic [LANES-1:0]          live;
  logic [CNT_W-1:0]          neg_cnt;
  logic signed [ACC_W-1:0]   tree_sum;
  logic signed [ACC_W-1:0]   acc_q;

  for (genvar i = 0; i < LANES; i++) begin : g_node
    logic [W-1:0] node_v;
    assign live[i]  = (32'(row_i) * LANES + i) < SEQ_LEN;
    // ~s == -s-1; the +1 comes in through the count leaf
    assign node_v   = coef_i[i] ? ~smp_i[i] : smp_i[i];
    assign leaf[i]  = live[i] ? {{(ACC_W-W){node_v[W-1]}}, node_v} : '0;
  end

  always_comb begin
    neg_cnt = '0;
    for (int i = 0; i < LANES; i++) neg_cnt = neg_cnt + CNT_W'(live[i] & coef_i[i]);
  end

  assign leaf[LANES] = {{(ACC_W-CNT_W){1'b0}}, neg_cnt};

  corr_adder_tree #(.N(LANES + 1), .W(ACC_W)) u_tree (
    .in_i  (leaf),
    .sum_o (tree_sum)
  );

  assign fin_o = (first_i ? '0 : acc_q) + tree_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= fin_o;
  end
endmodule

// File: rtl/ppt_correlator.sv
module ppt_correlator #(
  parameter int SMP_W   = 4,
  parameter int SEQ_LEN = 18,
  parameter int LANES   = 4,
  parameter int OFFSETS = 3,
  parameter int N_CODES = 2,
  parameter int DEPTH   = 64,
  parameter int GRP_W   = 3,
  localparam int ROWS   = corr_pkg::ceil_div(SEQ_LEN, LANES),
  localparam int AW     = corr_pkg::width_of(DEPTH),
  localparam int CW     = corr_pkg::width_of(N_CODES),
  localparam int RW     = corr_pkg::width_of(ROWS),
  localparam int ACC_W  = SMP_W + $clog2(SEQ_LEN) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_we_i,
  input  logic [AW-1:0]           smp_addr_i,
  input  logic [SMP_W-1:0]        smp_data_i,
  input  logic                    code_we_i,
  input  logic [CW-1:0]           code_wsel_i,
  input  logic [RW-1:0]           code_row_i,
  input  logic [LANES-1:0]        code_bits_i,
  input  logic                    start_i,
  input  logic [CW-1:0]           code_sel_i,
  input  logic [AW-1:0]           base_i,
  input  logic [GRP_W-1:0]        groups_i,
  output logic                    busy_o,
  output logic signed [ACC_W-1:0] res_o,
  output logic                    res_valid_o,
  output logic                    done_o
);
  localparam int WIN = LANES + OFFSETS - 1;
  localparam int OCW = $clog2(OFFSETS + 1);

  logic             busy_q;
  logic [RW-1:0]    row_q;
  logic [AW-1:0]    base_q;
  logic [CW-1:0]    code_q;
  logic [GRP_W-1:0] left_q;
  logic             last_row, final_row, accept;

  assign last_row  = busy_q && (row_q == RW'(ROWS - 1));
  assign final_row = last_row && (left_q == '0);
  // zero-gap restart allowed in the closing cycle of the job
  assign accept    = start_i && (!busy_q || final_row);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      row_q  <= '0;
      base_q <= '0;
      code_q <= '0;
      left_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      row_q  <= '0;
      base_q <= base_i;
      code_q <= code_sel_i;
      left_q <= groups_i;
    end else if (busy_q) begin
      if (last_row) begin
        row_q <= '0;
        if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
          base_q <= base_q + AW'(OFFSETS);
        end
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  logic [AW-1:0]             rbase;
  logic [WIN-1:0][SMP_W-1:0] win;
  logic [LANES-1:0]          coef;

  assign rbase = base_q + AW'(32'(row_q) * LANES);

  corr_sample_store #(.W(SMP_W), .DEPTH(DEPTH), .WIN(WIN), .AW(AW)) u_smp (
    .clk_i   (clk_i),
    .we_i    (smp_we_i),
    .waddr_i (smp_addr_i),
    .wdata_i (smp_data_i),
    .rbase_i (rbase),
    .win_o   (win)
  );

  corr_code_store #(.LANES(LANES), .N_CODES(N_CODES), .ROWS(ROWS), .CW(CW), .RW(RW)) u_code (
    .clk_i   (clk_i),
    .we_i    (code_we_i),
    .wsel_i  (code_wsel_i),
    .wrow_i  (code_row_i),
    .wbits_i (code_bits_i),
    .rsel_i  (code_q),
    .rrow_i  (row_q),
    .rbits_o (coef)
  );

  logic signed [ACC_W-1:0] fin [OFFSETS];

  for (genvar j = 0; j < OFFSETS; j++) begin : g_off
    corr_offset_lane #(
      .W(SMP_W), .LANES(LANES), .ACC_W(ACC_W), .SEQ_LEN(SEQ_LEN), .RW(RW)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (busy_q),
      .first_i (row_q == '0),
      .row_i   (row_q),
      .smp_i   (win[j +: LANES]),
      .coef_i  (coef),
      .fin_o   (fin[j])
    );
  end

  // result chain: parallel load on the closing row, shift toward res_o
  logic signed [ACC_W-1:0] res_q [OFFSETS];
  logic [OCW-1:0]          cnt_q;
  logic                    done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < OFFSETS; j++) res_q[j] <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == OCW'(1));
      if (last_row) begin
        for (int j = 0; j < OFFSETS; j++) res_q[j] <= fin[j];
        cnt_q <= OCW'(OFFSETS);
      end else if (cnt_q != '0) begin
        for (int j = 0; j < OFFSETS - 1; j++) res_q[j] <= res_q[j + 1];
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign res_o       = res_q[0];
  assign res_valid_o = (cnt_q != '0);
  assign done_o      = done_q;
endmodule

// File: rtl/ppt_correlator_chk.sv
module ppt_correlator_chk #(
  parameter int SEQ_LEN = 18,
  parameter int SMP_W   = 4,
  parameter int ACC_W   = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    res_valid_o,
  input logic signed [ACC_W-1:0] res_o
);
  localparam int LIM = SEQ_LEN * (1 << (SMP_W - 1));

  // R2: magnitude never exceeds the extreme sum
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_o <= LIM) && (res_o >= -LIM));

  // R7: done follows a result beat
  a_r7_done_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(res_valid_o));

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: a job only begins on a start
  a_r8_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R5: a burst of results only follows compute
  a_r5_beats_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> $past(busy_o));
endmodule

bind ppt_correlator ppt_correlator_chk #(
  .SEQ_LEN(SEQ_LEN), .SMP_W(SMP_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .res_valid_o (res_valid_o),
  .res_o       (res_o)
);

// File: tb/ppt_correlator_tb.sv
`timescale 1ns/1ps
module ppt_correlator_tb;
  localparam int SMP_W = 4, SEQ_LEN = 18, LANES = 4, OFFSETS = 3;
  localparam int N_CODES = 2, DEPTH = 64, GRP_W = 3;
  localparam int ROWS = 5, AW = 6, CW = 1, RW = 3, ACC_W = 10;
  localparam int LIM = SEQ_LEN * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_we = 0, code_we = 0, start = 0;
  logic [AW-1:0] smp_addr = '0, base = '0;
  logic [SMP_W-1:0] smp_data = '0;
  logic [CW-1:0] code_wsel = '0, code_sel = '0;
  logic [RW-1:0] code_row = '0;
  logic [LANES-1:0] code_bits = '0;
  logic [GRP_W-1:0] groups = '0;
  logic busy, res_valid, done;
  logic signed [ACC_W-1:0] res;

  always #2.5 clk = ~clk;

  ppt_correlator #(
    .SMP_W(SMP_W), .SEQ_LEN(SEQ_LEN), .LANES(LANES), .OFFSETS(OFFSETS),
    .N_CODES(N_CODES), .DEPTH(DEPTH), .GRP_W(GRP_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_we_i(smp_we), .smp_addr_i(smp_addr), .smp_data_i(smp_data),
    .code_we_i(code_we), .code_wsel_i(code_wsel), .code_row_i(code_row), .code_bits_i(code_bits),
    .start_i(start), .code_sel_i(code_sel), .base_i(base), .groups_i(groups),
    .busy_o(busy), .res_o(res), .res_valid_o(res_valid), .done_o(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int smem [DEPTH];
  bit cmem [N_CODES][ROWS*LANES];
  int got_v[$], got_c[$], got_d[$], exp_v[$], exp_c[$], exp_d[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin got_v.push_back(int'(res)); got_c.push_back(cyc); end
      if (done) got_d.push_back(cyc);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int ref_corr(int code, int b);
    int acc = 0;
    for (int p = 0; p < SEQ_LEN; p++) begin
      int s = smem[(b + p) % DEPTH];
      acc += cmem[code][p] ? -s : s;
    end
    return acc;
  endfunction

  task automatic expect_job(int s, int code, int b, int ng);
    for (int g = 0; g <= ng; g++) begin
      for (int j = 0; j < OFFSETS; j++) begin
        exp_v.push_back(ref_corr(code, b + g*OFFSETS + j));
        exp_c.push_back(s + ROWS*(g+1) + j);
      end
      exp_d.push_back(s + ROWS*(g+1) + OFFSETS);
    end
  endtask

  task automatic compare(string req);
    check(got_v.size() == exp_v.size(), req, "beat count", got_v.size(), exp_v.size());
    for (int i = 0; i < got_v.size() && i < exp_v.size(); i++) begin
      check(got_v[i] == exp_v[i], req, $sformatf("value beat %0d", i), got_v[i], exp_v[i]);
      check(got_c[i] == exp_c[i], req, $sformatf("cycle beat %0d", i), got_c[i], exp_c[i]);
    end
    check(got_d.size() == exp_d.size(), "R7", "done count", got_d.size(), exp_d.size());
    for (int i = 0; i < got_d.size() && i < exp_d.size(); i++)
      check(got_d[i] == exp_d[i], "R7", $sformatf("done cycle %0d", i), got_d[i], exp_d[i]);
    got_v.delete(); got_c.delete(); got_d.delete();
    exp_v.delete(); exp_c.delete(); exp_d.delete();
  endtask

  task automatic put_sample(int a, int v);
    smp_we = 1; smp_addr = AW'(a); smp_data = SMP_W'(v);
    @(negedge clk);
    smp_we = 0;
    smem[a] = v;
  endtask

  // chips past SEQ_LEN are written as 1 (-1) to expose a missing mask
  task automatic put_code(int sel);
    for (int r = 0; r < ROWS; r++) begin
      for (int i = 0; i < LANES; i++)
        code_bits[i] = (r*LANES + i < SEQ_LEN) ? cmem[sel][r*LANES + i] : 1'b1;
      code_we = 1; code_wsel = CW'(sel); code_row = RW'(r);
      @(negedge clk);
      code_we = 0;
    end
  endtask

  task automatic start_job(int code, int b, int ng, output int s);
    start = 1; code_sel = CW'(code); base = AW'(b); groups = GRP_W'(ng);
    @(negedge clk);
    start = 0;
    s = cyc;
  endtask

  task automatic drain(int ng);
    repeat ((ng + 1) * ROWS + OFFSETS + 4) @(negedge clk);
  endtask

  initial begin
    int s, s2, seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(busy == 0, "R10", "busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R10", "busy after reset", busy, 0);
    check(res_valid == 0, "R10", "valid after reset", res_valid, 0);
    check(done == 0, "R10", "done after reset", done, 0);

    // R2 extremes: all -8, code0 all -1, code1 all +1
    for (int a = 0; a < DEPTH; a++) put_sample(a, -8);
    for (int p = 0; p < ROWS*LANES; p++) begin cmem[0][p] = 1; cmem[1][p] = 0; end
    put_code(0); put_code(1);
    start_job(0, 0, 0, s); expect_job(s, 0, 0, 0); drain(0);
    check(exp_v[0] == LIM, "R2", "model max", exp_v[0], LIM);
    compare("R2");
    start_job(1, 7, 0, s); expect_job(s, 1, 7, 0); drain(0);
    check(exp_v[0] == -LIM, "R2", "model min", exp_v[0], -LIM);
    compare("R2");

    // R3 masked tail: samples only at 18..23, code0 all +1 within SEQ_LEN
    for (int a = 0; a < DEPTH; a++) put_sample(a, (a >= 18 && a < 24) ? 7 : 0);
    for (int p = 0; p < ROWS*LANES; p++) cmem[0][p] = 0;
    put_code(0);
    start_job(0, 0, 0, s); expect_job(s, 0, 0, 0); drain(0);
    check(exp_v[0] == 0 && exp_v[1] == 7 && exp_v[2] == 14, "R3", "model tail", exp_v[2], 14);
    compare("R3");

    // R11: rewrite code0 and rerun the same job
    for (int p = 0; p < SEQ_LEN; p++) cmem[0][p] = p[0];
    put_code(0);
    start_job(0, 0, 0, s); expect_job(s, 0, 0, 0); drain(0);
    compare("R11");

    // R1/R5/R6: random data, random jobs
    for (int a = 0; a < DEPTH; a++) put_sample(a, int'($urandom_range(15)) - 8);
    for (int c = 0; c < N_CODES; c++) begin
      for (int p = 0; p < ROWS*LANES; p++) cmem[c][p] = 1'($urandom_range(1));
      put_code(c);
    end
    for (int k = 0; k < 8; k++) begin
      int c = int'($urandom_range(1));
      int b = int'($urandom_range(DEPTH - 1));
      int ng = int'($urandom_range(3));
      start_job(c, b, ng, s); expect_job(s, c, b, ng); drain(ng);
      compare((ng > 0) ? "R6" : "R1");
    end
    start_job(1, 2, 3, s); expect_job(s, 1, 2, 3); drain(3);
    compare("R5");

    // R4: base near the end wraps
    start_job(0, 60, 1, s); expect_job(s, 0, 60, 1); drain(1);
    compare("R4");

    // R8: start mid-job is ignored
    start_job(0, 5, 2, s);
    repeat (3) @(negedge clk);
    start = 1; code_sel = 1; base = 30; groups = 0;
    @(negedge clk);
    start = 0;
    check(busy == 1, "R8", "busy kept", busy, 1);
    expect_job(s, 0, 5, 2); drain(2);
    compare("R8");

    // R9: back-to-back start with code switch in the closing cycle
    start_job(0, 10, 0, s);
    while (cyc != s + ROWS - 1) @(negedge clk);
    start_job(1, 40, 1, s2);
    check(s2 == s + ROWS, "R9", "restart edge", s2, s + ROWS);
    expect_job(s, 0, 10, 0); expect_job(s2, 1, 40, 1); drain(2);
    compare("R9");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule